// File: doc/BRIEF.md
# Converter Status Event and Interrupt Controller

This block gathers fault and health conditions from two voltage-converter channels, plus three chip-wide conditions, and turns each one into a sticky event flag. Per channel the conditions are over-current, over-voltage, under-voltage and power-good. Chip-wide, they are temperature warning, critical temperature and input under-voltage lockout.

An event flag is set when its condition rises. It stays set until software writes a 1 to it. A per-source mask bit decides whether a set event pulls the shared active-low interrupt line. The line is meant to feed an open-drain pad driver that sits outside this block.

Software reaches the block through a plain register port. The port has an address, a write strobe, write data and combinational read data. There are six registers: two that mirror the conditions, two that hold the events and two that hold the masks. A chip-enable input also feeds the block. On each rising edge of chip-enable, the masks return to their defaults. The event flags keep their state on that edge, unless a configuration input asks for them to be wiped as well.

Top module: `irq_status_ctrl`

## Requirements
- R1: The channel condition register (offset 0) reads, from bit 7 to bit 0: OC ch2, OC ch1, OV ch2, OV ch1, UV ch2, UV ch1, PG ch2, PG ch1. The chip condition register (offset 1) reads temperature warning in bit 2, critical temperature in bit 1 and input UVLO in bit 0. Both show the condition values sampled at the most recent clock edge.
- R2: A condition that was 0 at one clock edge and is 1 at the next sets its event bit at that next edge. The event registers at offsets 2 and 3 use the same bit positions as the condition registers.
- R3: Writing a 1 to an event bit clears it, and writing a 0 leaves it unchanged. If a new rise arrives in the same cycle as the clearing write, the bit stays set.
- R4: After reset, the event registers read 0x00, the masks read 0xFF (offset 4) and 0x07 (offset 5), and irq_n is 1.
- R5: irq_n is 0 exactly when at least one event bit is set while its mask bit is 0. It follows the register state with no added cycle.
- R6: Once irq_n is low, a condition falling back to 0 does not release it. Only clearing or masking the pending events does.
- R7: Each source has its own mask bit, at the same bit position, in the mask registers at offsets 4 and 5. The mask registers are written directly. A masked event still reads as set.
- R8: A rising edge of chip_en reloads both masks to their reset values at the next clock edge. The event bits keep their state when ev_clr_on_ce is 0.
- R9: When ev_clr_on_ce is 1, a rising edge of chip_en clears all event bits. This clear overrides any condition rise in the same cycle.
- R10: Bits 7..3 of offsets 1, 3 and 5 read 0 and ignore writes. Any address outside offsets 0..5 reads 0.
- R11: Writes to the condition registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; a rising edge reloads the masks |
| ev_clr_on_ce | input | 1 | When 1, a chip_en rise also wipes the events |
| ch_oc | input | 2 | Over-current condition, bit 1 = channel 2 |
| ch_ov | input | 2 | Over-voltage condition, bit 1 = channel 2 |
| ch_uv | input | 2 | Under-voltage condition, bit 1 = channel 2 |
| ch_pg | input | 2 | Power-good condition, bit 1 = channel 2 |
| temp_warn | input | 1 | Temperature warning condition |
| temp_crit | input | 1 | Critical temperature condition |
| vin_uvlo | input | 1 | Input under-voltage lockout condition |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that every condition input, and chip_en, is synchronous to clk and held stable across each edge. They also assume that reg_addr, reg_wr and reg_wdata change only between edges, and that a register write lasts exactly one cycle per strobe.

The stickiness property treats a write strobe and a chip_en rise as the only ways pending events can be released. This means irq_n may change from low to high only in a cycle that follows one of those two.

The bench drives every input at the falling clock edge from one process. It toggles conditions and chip_en sparsely, so rises, falls and reload edges happen one at a time and also overlap with writes.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int DW        = 8;
  localparam int CH_SRCS   = 8;
  localparam int CHIP_SRCS = 3;
  localparam int NUM_REGS  = 6;

  typedef enum int {
    SLOT_STAT_CH   = 0,
    SLOT_STAT_CHIP = 1,
    SLOT_EVT_CH    = 2,
    SLOT_EVT_CHIP  = 3,
    SLOT_MSK_CH    = 4,
    SLOT_MSK_CHIP  = 5
  } reg_slot_e;

  // Next event state: wipe dominates, then a fresh rise beats a W1C clear.
  function automatic logic [DW-1:0] evt_next(
    input logic [DW-1:0] ev,
    input logic [DW-1:0] rise,
    input logic [DW-1:0] w1c,
    input logic          wipe
  );
    if (wipe) return '0;
    return (ev & ~w1c) | rise;
  endfunction

  // Any unmasked event pending.
  function automatic logic pend_any(
    input logic [DW-1:0] ev,
    input logic [DW-1:0] msk
  );
    return |(ev & ~msk);
  endfunction

  // Zero-extend a narrow field to the register width.
  function automatic logic [DW-1:0] zpad3(input logic [CHIP_SRCS-1:0] v);
    return {{(DW-CHIP_SRCS){1'b0}}, v};
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
    assign rise[i] = d[i] & ~q[i];
  end

endmodule

// File: rtl/irq_evt_bank.sv
module irq_evt_bank
  import irq_stat_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic         ev_wr,
  input  logic         msk_wr,
  input  logic [W-1:0] wdata,
  input  logic         reload,
  input  logic         wipe,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] mask_q,
  output logic         pend
);

  logic [DW-1:0] w1c_ext;
  logic [DW-1:0] ev_nxt_ext;
  logic [W-1:0]  ev_nxt;
  logic [W-1:0]  mask_nxt;

  always_comb begin
    w1c_ext    = ev_wr ? DW'(wdata) : '0;
    ev_nxt_ext = evt_next(DW'(ev_q), DW'(rise), w1c_ext, wipe);
    ev_nxt     = ev_nxt_ext[W-1:0];
  end

  always_comb begin
    if (reload)      mask_nxt = MASK_RST;
    else if (msk_wr) mask_nxt = wdata;
    else             mask_nxt = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= MASK_RST;
    end else begin
      ev_q   <= ev_nxt;
      mask_q <= mask_nxt;
    end
  end

  assign pend = pend_any(DW'(ev_q), ~DW'(~mask_q));

endmodule

// File: rtl/irq_reg_rmux.sv
module irq_reg_rmux
  import irq_stat_pkg::*;
(
  input  logic [NUM_REGS-1:0]  hit,
  input  logic [CH_SRCS-1:0]   stat_ch,
  input  logic [CHIP_SRCS-1:0] stat_chip,
  input  logic [CH_SRCS-1:0]   ev_ch,
  input  logic [CHIP_SRCS-1:0] ev_chip,
  input  logic [CH_SRCS-1:0]   mask_ch,
  input  logic [CHIP_SRCS-1:0] mask_chip,
  output logic [DW-1:0]        rdata
);

  logic [DW-1:0] slot_val [NUM_REGS];

  always_comb begin
    slot_val[SLOT_STAT_CH]   = DW'(stat_ch);
    slot_val[SLOT_STAT_CHIP] = zpad3(stat_chip);
    slot_val[SLOT_EVT_CH]    = DW'(ev_ch);
    slot_val[SLOT_EVT_CHIP]  = zpad3(ev_chip);
    slot_val[SLOT_MSK_CH]    = DW'(mask_ch);
    slot_val[SLOT_MSK_CHIP]  = zpad3(mask_chip);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      rdata = rdata | (slot_val[i] & {DW{hit[i]}});
    end
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int AW   = 8,
  parameter int BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en,
  input  logic          ev_clr_on_ce,
  input  logic [1:0]    ch_oc,
  input  logic [1:0]    ch_ov,
  input  logic [1:0]    ch_uv,
  input  logic [1:0]    ch_pg,
  input  logic          temp_warn,
  input  logic          temp_crit,
  input  logic          vin_uvlo,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);

  // Named internal events, brought out for the checker.
  logic [CH_SRCS-1:0]   cond_ch, stat_ch, rise_ch, ev_ch, mask_ch;
  logic [CHIP_SRCS-1:0] cond_chip, stat_chip, rise_chip, ev_chip, mask_chip;
  logic                 ce_q, ce_rise, ev_wipe;
  logic                 pend_ch, pend_chip;
  logic [NUM_REGS-1:0]  hit;

  // Bit order of the channel bank is decoded by software: keep it fixed.
  assign cond_ch   = {ch_oc[1], ch_oc[0], ch_ov[1], ch_ov[0],
                      ch_uv[1], ch_uv[0], ch_pg[1], ch_pg[0]};
  assign cond_chip = {temp_warn, temp_crit, vin_uvlo};

  for (genvar s = 0; s < NUM_REGS; s++) begin : g_dec
    assign hit[s] = (reg_addr == AW'(BASE + s));
  end

  irq_edge_det #(.W(CH_SRCS)) u_ed_ch (
    .clk(clk), .rst_n(rst_n), .d(cond_ch), .q(stat_ch), .rise(rise_ch)
  );

  irq_edge_det #(.W(CHIP_SRCS)) u_ed_chip (
    .clk(clk), .rst_n(rst_n), .d(cond_chip), .q(stat_chip), .rise(rise_chip)
  );

  irq_edge_det #(.W(1)) u_ed_ce (
    .clk(clk), .rst_n(rst_n), .d(chip_en), .q(ce_q), .rise(ce_rise)
  );

  assign ev_wipe = ce_rise & ev_clr_on_ce;

  irq_evt_bank #(.W(CH_SRCS), .MASK_RST(8'hFF)) u_bank_ch (
    .clk(clk), .rst_n(rst_n), .rise(rise_ch),
    .ev_wr(reg_wr & hit[SLOT_EVT_CH]), .msk_wr(reg_wr & hit[SLOT_MSK_CH]),
    .wdata(reg_wdata[CH_SRCS-1:0]), .reload(ce_rise), .wipe(ev_wipe),
    .ev_q(ev_ch), .mask_q(mask_ch), .pend(pend_ch)
  );

  irq_evt_bank #(.W(CHIP_SRCS), .MASK_RST(3'h7)) u_bank_chip (
    .clk(clk), .rst_n(rst_n), .rise(rise_chip),
    .ev_wr(reg_wr & hit[SLOT_EVT_CHIP]), .msk_wr(reg_wr & hit[SLOT_MSK_CHIP]),
    .wdata(reg_wdata[CHIP_SRCS-1:0]), .reload(ce_rise), .wipe(ev_wipe),
    .ev_q(ev_chip), .mask_q(mask_chip), .pend(pend_chip)
  );

  irq_reg_rmux u_rmux (
    .hit(hit), .stat_ch(stat_ch), .stat_chip(stat_chip),
    .ev_ch(ev_ch), .ev_chip(ev_chip), .mask_ch(mask_ch), .mask_chip(mask_chip),
    .rdata(reg_rdata)
  );

  assign irq_n = ~(pend_ch | pend_chip);

  logic unused_ok;
  assign unused_ok = ce_q;

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int AW   = 8,
  parameter int BASE = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_rise,
  input logic          ev_clr_on_ce,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_rdata,
  input logic          irq_n,
  input logic [7:0]    rise_ch,
  input logic [2:0]    rise_chip,
  input logic [7:0]    ev_ch,
  input logic [2:0]    ev_chip,
  input logic [7:0]    mask_ch,
  input logic [2:0]    mask_chip
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_EVT_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(ce_rise && ev_clr_on_ce)) |=>
      (((ev_ch & $past(rise_ch)) == $past(rise_ch)) &&
       ((ev_chip & $past(rise_chip)) == $past(rise_chip)))); // R2

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !irq_n && !reg_wr && !ce_rise) |=> !irq_n); // R6

  AST_MASK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ce_rise) |=> (mask_ch == 8'hFF && mask_chip == 3'h7)); // R8

  AST_EVT_KEEP_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ce_rise && !ev_clr_on_ce && !reg_wr) |=>
      (((ev_ch & $past(ev_ch)) == $past(ev_ch)) &&
       ((ev_chip & $past(ev_chip)) == $past(ev_chip)))); // R8

  AST_EVT_WIPE_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ce_rise && ev_clr_on_ce) |=> (ev_ch == 8'h00 && ev_chip == 3'h0)); // R9

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(BASE + 1) || reg_addr == AW'(BASE + 3) ||
     reg_addr == AW'(BASE + 5)) |-> (reg_rdata[7:3] == 5'b0)); // R10

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_rise(ce_rise), .ev_clr_on_ce(ev_clr_on_ce),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_n(irq_n),
  .rise_ch(rise_ch), .rise_chip(rise_chip), .ev_ch(ev_ch), .ev_chip(ev_chip),
  .mask_ch(mask_ch), .mask_chip(mask_chip)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en = 1'b0, ev_clr_on_ce = 1'b0;
  logic [1:0] ch_oc = '0, ch_ov = '0, ch_uv = '0, ch_pg = '0;
  logic       temp_warn = 1'b0, temp_crit = 1'b0, vin_uvlo = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model state
  logic [7:0] m_st0 = '0, m_ev0 = '0, m_mk0 = 8'hFF;
  logic [2:0] m_st1 = '0, m_ev1 = '0, m_mk1 = 3'h7;
  logic       m_ce = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ev_clr_on_ce(ev_clr_on_ce),
    .ch_oc(ch_oc), .ch_ov(ch_ov), .ch_uv(ch_uv), .ch_pg(ch_pg),
    .temp_warn(temp_warn), .temp_crit(temp_crit), .vin_uvlo(vin_uvlo),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'd0: return m_st0;
      8'd1: return {5'b0, m_st1};
      8'd2: return m_ev0;
      8'd3: return {5'b0, m_ev1};
      8'd4: return m_mk0;
      8'd5: return {5'b0, m_mk1};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'd0, 8'd1: return "R1";
      8'd2, 8'd3: return "R2";
      8'd4, 8'd5: return "R7";
      default:    return "R10";
    endcase
  endfunction

  function automatic logic exp_irq_n();
    return !(((m_ev0 & ~m_mk0) != 0) || ((m_ev1 & ~m_mk1) != 0));
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] c0, r0;
    logic [2:0] c1, r1;
    logic       cr;
    c0 = {ch_oc, ch_ov, ch_uv, ch_pg};
    c1 = {temp_warn, temp_crit, vin_uvlo};
    r0 = c0 & ~m_st0;
    r1 = c1 & ~m_st1;
    cr = chip_en & ~m_ce;
    if (cr && ev_clr_on_ce) begin
      m_ev0 = '0; m_ev1 = '0;
    end else begin
      if (reg_wr && reg_addr == 8'd2) m_ev0 = m_ev0 & ~reg_wdata;
      if (reg_wr && reg_addr == 8'd3) m_ev1 = m_ev1 & ~reg_wdata[2:0];
      m_ev0 = m_ev0 | r0;
      m_ev1 = m_ev1 | r1;
    end
    if (cr) begin
      m_mk0 = 8'hFF; m_mk1 = 3'h7;
    end else begin
      if (reg_wr && reg_addr == 8'd4) m_mk0 = reg_wdata;
      if (reg_wr && reg_addr == 8'd5) m_mk1 = reg_wdata[2:0];
    end
    m_st0 = c0; m_st1 = c1; m_ce = chip_en;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk(tag_of(reg_addr), reg_rdata, exp_read(reg_addr));
    chk("R5", {7'b0, irq_n}, {7'b0, exp_irq_n()});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a;
    tick();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    rd(8'd4); chk("R4", reg_rdata, 8'hFF);
    rd(8'd5); chk("R4", reg_rdata, 8'h07);
    rd(8'd2); chk("R4", reg_rdata, 8'h00);
    chk("R4", {7'b0, irq_n}, 8'h01);

    // R1 / R2: channel 2 over-current at bit 7
    ch_oc = 2'b10;
    rd(8'd0); chk("R1", reg_rdata, 8'h80);
    rd(8'd2); chk("R2", reg_rdata, 8'h80);
    chk("R7", {7'b0, irq_n}, 8'h01);      // masked event: no request
    ch_pg = 2'b01;
    rd(8'd2); chk("R2", reg_rdata, 8'h81);

    // R5: unmask bit 7 only
    wr(8'd4, 8'h7F);
    chk("R5", {7'b0, irq_n}, 8'h00);

    // R6: condition falls, request stays
    ch_oc = 2'b00;
    rd(8'd0); rd(8'd0);
    chk("R6", {7'b0, irq_n}, 8'h00);

    // R3: write 0 keeps, write 1 clears
    wr(8'd2, 8'h00); rd(8'd2); chk("R3", reg_rdata, 8'h81);
    wr(8'd2, 8'h80); rd(8'd2); chk("R3", reg_rdata, 8'h01);
    chk("R3", {7'b0, irq_n}, 8'h01);

    // R11: condition registers ignore writes
    wr(8'd0, 8'hFF); rd(8'd0); chk("R11", reg_rdata, 8'h01);

    // R10: reserved bits and unmapped addresses
    wr(8'd5, 8'hFF); rd(8'd5); chk("R10", reg_rdata, 8'h07);
    rd(8'h20); chk("R10", reg_rdata, 8'h00);

    // R2 chip bank: temperature warning at bit 2
    temp_warn = 1'b1;
    rd(8'd3); chk("R2", reg_rdata, 8'h04);
    wr(8'd5, 8'h03);
    chk("R5", {7'b0, irq_n}, 8'h00);

    // R8: chip_en rise reloads masks, keeps events
    chip_en = 1'b1; ev_clr_on_ce = 1'b0;
    rd(8'd5); chk("R8", reg_rdata, 8'h07);
    rd(8'd3); chk("R8", reg_rdata, 8'h04);
    chk("R8", {7'b0, irq_n}, 8'h01);

    // R9: wipe on chip_en rise overrides a same-cycle rise
    chip_en = 1'b0; rd(8'd3);
    ev_clr_on_ce = 1'b1; chip_en = 1'b1; temp_crit = 1'b1;
    rd(8'd3); chk("R9", reg_rdata, 8'h00);
    rd(8'd2); chk("R9", reg_rdata, 8'h00);

    // R3: a rise beats a same-cycle clearing write
    vin_uvlo = 1'b1;
    wr(8'd3, 8'h01);
    rd(8'd3); chk("R3", reg_rdata, 8'h01);

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) == 0) ch_oc = ch_oc ^ 2'($urandom_range(1, 3));
      if ($urandom_range(0, 9) == 0) ch_ov = ch_ov ^ 2'($urandom_range(1, 3));
      if ($urandom_range(0, 9) == 0) ch_uv = ch_uv ^ 2'($urandom_range(1, 3));
      if ($urandom_range(0, 9) == 0) ch_pg = ch_pg ^ 2'($urandom_range(1, 3));
      if ($urandom_range(0, 11) == 0) temp_warn = ~temp_warn;
      if ($urandom_range(0, 11) == 0) temp_crit = ~temp_crit;
      if ($urandom_range(0, 11) == 0) vin_uvlo = ~vin_uvlo;
      if ($urandom_range(0, 29) == 0) begin
        chip_en = ~chip_en;
        ev_clr_on_ce = 1'($urandom_range(0, 1));
      end
      reg_wr    = ($urandom_range(0, 2) == 0);
      reg_addr  = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(6, 255))
                                               : 8'($urandom_range(0, 5));
      reg_wdata = 8'($urandom);
      tick();
    end
    reg_wr = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule